// File: doc/BRIEF.md
# Twin-Predicated Element Move Sequencer

This block carries out a vector register-to-register copy in which the source side and the destination side each have their own predicate mask and their own scalar-or-vector mode. After a start pulse it walks two element indices separately. On each side it skips directly to the next set mask bit below the vector length. It then moves one element per clock from the source register to the destination register in a local register file. When either side runs out of eligible elements, or when a scalar destination has received its single element, it raises a one-cycle done pulse.

Each side can be scalar or vector, so the same walk can broadcast one register across a vector, scatter a scalar into one selected slot, gather one selected element into a scalar, or compress and expand between two sparse masks. Register numbers wrap around the end of the file. A separate test port loads and reads the register file directly.

Top module: `tpmove_seq`

## Requirements
- R1: After reset, busy, done and mv_we are all low.
- R2: Bit i of src_mask enables source element i, and bit i of dst_mask enables destination element i. The n-th enabled source element is written to the n-th enabled destination element. Each side skips its own clear bits.
- R3: A side whose scalar flag is 1 always uses its base register. A vector side uses base plus element index. With all-ones masks, a scalar source and a vector destination, the base source value is copied into destination elements 0 to vl-1.
- R4: With an all-ones src_mask, a scalar source and dst_mask equal to 1<<k (k < vl), exactly one write occurs, to register dst_base+k, and it carries the value of register src_base.
- R5: With src_mask equal to 1<<k (k < vl), a vector source and a scalar destination, exactly one write occurs, to register dst_base, with the value of register src_base+k. The operation then finishes.
- R6: If either side has no set mask bit left below vl, the operation finishes without a further write. A mask bit at or above vl never causes a write.
- R7: One element moves per busy clock, whatever the number of clear mask bits skipped. Busy lasts one cycle per write, plus one closing cycle unless the last write was to a scalar destination or used source or destination index vl-1.
- R8: With vl equal to 0 there is no write, and busy lasts exactly one cycle before done.
- R9: Register numbers are formed modulo 128, so base plus index wraps past register 127 to register 0.
- R10: done is high for exactly one cycle per operation. A start while busy is ignored and changes neither the result nor the number of done pulses.
- R11: A test write to tp_addr takes effect at the next clock edge. tp_rdata shows the contents of register tp_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| src_base | input | 7 | Source base register number |
| dst_base | input | 7 | Destination base register number |
| src_scalar | input | 1 | 1: source register index stays fixed |
| dst_scalar | input | 1 | 1: destination fixed, single write |
| vl | input | 7 | Vector length, 0 to 64 |
| src_mask | input | 64 | Source predicate, bit i for element i |
| dst_mask | input | 64 | Destination predicate, bit i for element i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mv_we | output | 1 | An element is being written this cycle |
| mv_addr | output | 7 | Destination register of the current write |
| mv_data | output | DATA_W | Value being written |
| tp_we | input | 1 | Test port write enable |
| tp_addr | input | 7 | Test port register number |
| tp_wdata | input | DATA_W | Test port write data |
| tp_rdata | output | DATA_W | Test port read data |

## Verification
The bench builds the block with 128 registers and a maximum vector length of 64, the full default address and mask widths, and only narrows DATA_W to 16 bits. This makes a full-length 64-element copy possible, as well as bases near register 127 that wrap to register 0 with the source and destination ranges overlapping. Mask bits that lie between vl and the top of the mask can also be set to show that they are ignored. A reference walk in the bench predicts the write count, the busy length and all 128 register values for each case.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tpm_state_e;
endpackage

// File: rtl/tpm_pick.sv
// Finds the lowest set mask bit at or above `from` and below `lim`.
module tpm_pick #(
    parameter int N  = 64,
    parameter int IW = 7
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] from,
    input  logic [IW-1:0] lim,
    output logic          hit,
    output logic [IW-1:0] pos
);
    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (IW'(i) >= from) && (IW'(i) < lim)) begin
                hit = 1'b1;
                pos = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tpm_addr.sv
// Register number for one side: fixed base when scalar, wrapped base+index otherwise.
module tpm_addr #(
    parameter int AW    = 7,
    parameter int IW    = 7,
    parameter int DEPTH = 128
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] idx,
    input  logic          scalar,
    output logic [AW-1:0] addr
);
    logic [AW:0] sum;

    always_comb begin
        sum  = {1'b0, base} + (AW+1)'(idx);
        addr = scalar ? base : AW'(sum % (AW+1)'(DEPTH));
    end
endmodule

// File: rtl/tpm_regfile.sv
module tpm_regfile #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 128,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic [AW-1:0]     mv_raddr,
    output logic [DATA_W-1:0] mv_rdata,
    input  logic              mv_we,
    input  logic [AW-1:0]     mv_waddr,
    input  logic [DATA_W-1:0] mv_wdata,
    input  logic              tp_we,
    input  logic [AW-1:0]     tp_addr,
    input  logic [DATA_W-1:0] tp_wdata,
    output logic [DATA_W-1:0] tp_rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (mv_we) begin
            mem_q[mv_waddr] <= mv_wdata;
        end else if (tp_we) begin
            mem_q[tp_addr] <= tp_wdata;
        end
    end

    assign mv_rdata = mem_q[mv_raddr];
    assign tp_rdata = mem_q[tp_addr];
endmodule

// File: rtl/tpmove_seq.sv
module tpmove_seq #(
    parameter int DATA_W  = 64,
    parameter int REG_NUM = 128,
    parameter int MAX_VL  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [$clog2(REG_NUM)-1:0] src_base,
    input  logic [$clog2(REG_NUM)-1:0] dst_base,
    input  logic                       src_scalar,
    input  logic                       dst_scalar,
    input  logic [$clog2(MAX_VL+1)-1:0] vl,
    input  logic [MAX_VL-1:0]          src_mask,
    input  logic [MAX_VL-1:0]          dst_mask,
    output logic                       busy,
    output logic                       done,
    output logic                       mv_we,
    output logic [$clog2(REG_NUM)-1:0] mv_addr,
    output logic [DATA_W-1:0]          mv_data,
    input  logic                       tp_we,
    input  logic [$clog2(REG_NUM)-1:0] tp_addr,
    input  logic [DATA_W-1:0]          tp_wdata,
    output logic [DATA_W-1:0]          tp_rdata
);
    import tpm_pkg::*;

    localparam int AW = $clog2(REG_NUM);
    localparam int IW = $clog2(MAX_VL + 1);

    typedef struct packed {
        tpm_state_e        st;
        logic [AW-1:0]     sb;
        logic [AW-1:0]     db;
        logic              ss;
        logic              ds;
        logic [IW-1:0]     vl;
        logic [MAX_VL-1:0] sm;
        logic [MAX_VL-1:0] dm;
        logic [IW-1:0]     si;
        logic [IW-1:0]     di;
        logic              done;
    } seq_t;

    seq_t r_q, r_d;

    logic          s_hit, d_hit;
    logic [IW-1:0] s_pos, d_pos;
    logic [AW-1:0] src_addr, dst_addr;
    logic [IW-1:0] s_nx, d_nx;

    // One encoder per side: each skips its own clear mask bits.
    for (genvar g = 0; g < 2; g++) begin : g_side
        if (g == 0) begin : g_src
            tpm_pick #(.N(MAX_VL), .IW(IW)) u_pick (
                .mask(r_q.sm), .from(r_q.si), .lim(r_q.vl), .hit(s_hit), .pos(s_pos)
            );
            tpm_addr #(.AW(AW), .IW(IW), .DEPTH(REG_NUM)) u_addr (
                .base(r_q.sb), .idx(s_pos), .scalar(r_q.ss), .addr(src_addr)
            );
        end else begin : g_dst
            tpm_pick #(.N(MAX_VL), .IW(IW)) u_pick (
                .mask(r_q.dm), .from(r_q.di), .lim(r_q.vl), .hit(d_hit), .pos(d_pos)
            );
            tpm_addr #(.AW(AW), .IW(IW), .DEPTH(REG_NUM)) u_addr (
                .base(r_q.db), .idx(d_pos), .scalar(r_q.ds), .addr(dst_addr)
            );
        end
    end

    assign mv_we   = (r_q.st == ST_RUN) && s_hit && d_hit;
    assign mv_addr = dst_addr;
    assign busy    = (r_q.st == ST_RUN);
    assign done    = r_q.done;

    tpm_regfile #(.DATA_W(DATA_W), .DEPTH(REG_NUM), .AW(AW)) u_rf (
        .clk      (clk),
        .mv_raddr (src_addr),
        .mv_rdata (mv_data),
        .mv_we    (mv_we),
        .mv_waddr (dst_addr),
        .mv_wdata (mv_data),
        .tp_we    (tp_we),
        .tp_addr  (tp_addr),
        .tp_wdata (tp_wdata),
        .tp_rdata (tp_rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        s_nx     = s_pos + IW'(1);
        d_nx     = d_pos + IW'(1);
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st = ST_RUN;
                    r_d.sb = src_base;
                    r_d.db = dst_base;
                    r_d.ss = src_scalar;
                    r_d.ds = dst_scalar;
                    r_d.vl = vl;
                    r_d.sm = src_mask;
                    r_d.dm = dst_mask;
                    r_d.si = '0;
                    r_d.di = '0;
                end
            end
            default: begin
                if (!(s_hit && d_hit)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.si = s_nx;
                    r_d.di = d_nx;
                    if (r_q.ds || (s_nx >= r_q.vl) || (d_nx >= r_q.vl)) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R6: every write uses element positions inside the vector length
    a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mv_we |-> ((s_pos < r_q.vl) && (d_pos < r_q.vl)));

    // R10: done never lasts two cycles
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: configuration held while busy, start ignored
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(r_q.vl) && $stable(r_q.sm) && $stable(r_q.dm)
                             && $stable(r_q.sb) && $stable(r_q.db)));

    // R5: a scalar destination ends the operation after its single write
    a_r5_scalar_dst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_we && r_q.ds) |=> (done && !busy));

    // R3: a scalar source reads its base register only
    a_r3_scalar_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_we && r_q.ss) |-> (src_addr == r_q.sb));

    // R1: no write outside an operation
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mv_we);
endmodule

// File: tb/tb_tpmove_seq.sv
`timescale 1ns/1ps
module tb_tpmove_seq;
    localparam int DW = 16;
    localparam int NR = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [6:0]    src_base = '0, dst_base = '0;
    logic          src_scalar = 1'b0, dst_scalar = 1'b0;
    logic [6:0]    vl = '0;
    logic [63:0]   src_mask = '0, dst_mask = '0;
    logic          busy, done, mv_we;
    logic [6:0]    mv_addr;
    logic [DW-1:0] mv_data;
    logic          tp_we = 1'b0;
    logic [6:0]    tp_addr = '0;
    logic [DW-1:0] tp_wdata = '0;
    logic [DW-1:0] tp_rdata;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] expm [NR];

    always #4 clk = ~clk;

    tpmove_seq #(.DATA_W(DW), .REG_NUM(NR), .MAX_VL(64)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .src_scalar(src_scalar), .dst_scalar(dst_scalar),
        .vl(vl), .src_mask(src_mask), .dst_mask(dst_mask),
        .busy(busy), .done(done), .mv_we(mv_we), .mv_addr(mv_addr), .mv_data(mv_data),
        .tp_we(tp_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
    );

    typedef struct packed {
        logic [6:0]  sb;
        logic [6:0]  db;
        logic        ss;
        logic        ds;
        logic [6:0]  vl;
        logic [63:0] sm;
        logic [63:0] dm;
        logic [7:0]  ew;   // expected write count
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R3 splat scalar source into vector
        '{7'd5,   7'd20,  1'b1, 1'b0, 7'd8,  {64{1'b1}}, {64{1'b1}}, 8'd8,  4'd3},
        // R7 dense full-length copy
        '{7'd0,   7'd64,  1'b0, 1'b0, 7'd64, {64{1'b1}}, {64{1'b1}}, 8'd64, 4'd7},
        // R4 single destination bit k=5
        '{7'd3,   7'd40,  1'b1, 1'b0, 7'd16, {64{1'b1}}, 64'h20,     8'd1,  4'd4},
        // R5 single source bit k=9 into scalar destination
        '{7'd10,  7'd100, 1'b0, 1'b1, 7'd16, 64'h200,    {64{1'b1}}, 8'd1,  4'd5},
        // R2 sparse masks on both sides
        '{7'd0,   7'd50,  1'b0, 1'b0, 7'd8,  64'hA5,     64'h3C,     8'd4,  4'd2},
        // R9 wrap past register 127 with overlap
        '{7'd120, 7'd124, 1'b0, 1'b0, 7'd12, {64{1'b1}}, {64{1'b1}}, 8'd12, 4'd9},
        // R6 selected source bit beyond vl
        '{7'd30,  7'd90,  1'b0, 1'b1, 7'd10, 64'h100000, {64{1'b1}}, 8'd0,  4'd6},
        // R8 zero vector length
        '{7'd1,   7'd2,   1'b0, 1'b0, 7'd0,  {64{1'b1}}, {64{1'b1}}, 8'd0,  4'd8},
        // R6 empty destination mask
        '{7'd7,   7'd70,  1'b0, 1'b0, 7'd8,  {64{1'b1}}, 64'h0,      8'd0,  4'd6}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic preload(input int seed);
        for (int i = 0; i < NR; i++) begin
            @(negedge clk);
            tp_we    = 1'b1;
            tp_addr  = 7'(i);
            tp_wdata = DW'(i * 16'h0131 + seed * 16'h0707 + 16'h1000);
            expm[i]  = DW'(i * 16'h0131 + seed * 16'h0707 + 16'h1000);
        end
        @(negedge clk);
        tp_we = 1'b0;
    endtask

    // Reference walk built from the requirements.
    task automatic model(input vec_t v, output int nw, output int ncyc);
        int s = 0;
        int d = 0;
        nw = 0;
        ncyc = 0;
        while (1) begin
            int sp = -1;
            int dp = -1;
            int sa, da;
            ncyc++;
            for (int i = s; i < int'(v.vl) && i < 64; i++)
                if (v.sm[i] && sp < 0) sp = i;
            for (int i = d; i < int'(v.vl) && i < 64; i++)
                if (v.dm[i] && dp < 0) dp = i;
            if (sp < 0 || dp < 0) break;
            sa = v.ss ? int'(v.sb) : (int'(v.sb) + sp) % NR;
            da = v.ds ? int'(v.db) : (int'(v.db) + dp) % NR;
            expm[da] = expm[sa];
            nw++;
            s = sp + 1;
            d = dp + 1;
            if (v.ds || s >= int'(v.vl) || d >= int'(v.vl)) break;
        end
    endtask

    task automatic run_op(input vec_t v, input int seed, input bit poke);
        int nw, ncyc;
        int got_w = 0;
        int got_c = 0;
        int mism = 0;
        int guard = 0;
        int bad_addr = -1;
        string rq;
        rq = $sformatf("R%0d", v.req);
        preload(seed);
        model(v, nw, ncyc);
        check(nw == int'(v.ew), rq, "model write count", nw, v.ew);
        @(negedge clk);
        src_base = v.sb; dst_base = v.db; src_scalar = v.ss; dst_scalar = v.ds;
        vl = v.vl; src_mask = v.sm; dst_mask = v.dm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 1000) begin
            if (busy) got_c++;
            if (mv_we) got_w++;
            if (poke && got_c == 3) begin
                // R10: start while busy with a different setup
                start = 1'b1; vl = 7'd1; src_mask = '0; dst_base = 7'd0;
            end else begin
                start = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b1, rq, "done seen", done, 1);
        check(got_w == nw, rq, "writes", got_w, nw);
        check(got_c == ncyc, "R7", "busy cycles", got_c, ncyc);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R10", "done width / idle", done, 0);
        for (int i = 0; i < NR; i++) begin
            tp_addr = 7'(i);
            #1;
            if (tp_rdata !== expm[i]) begin
                if (bad_addr < 0) bad_addr = i;
                mism++;
            end
        end
        check(mism == 0, rq, $sformatf("register file contents, first bad reg %0d", bad_addr),
              mism, 0);
    endtask

    initial begin
        #1600000;
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(mv_we == 1'b0, "R1", "mv_we in reset", mv_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", busy, 0);

        // R11 test port write and same-cycle readback
        tp_we = 1'b1; tp_addr = 7'd77; tp_wdata = 16'hBEEF;
        @(negedge clk);
        tp_we = 1'b0; tp_addr = 7'd77;
        #1;
        check(tp_rdata == 16'hBEEF, "R11", "test readback", tp_rdata, 16'hBEEF);

        for (int k = 0; k < NV; k++) begin
            run_op(VECS[k], k + 1, 1'b0);
        end

        // R10: start pulses while busy have no effect on the result
        run_op(VECS[1], 20, 1'b1);
        run_op(VECS[4], 21, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule